// File: doc/BRIEF.md
# Debug cache tag readout engine

This block lets a debugger look inside a cache without disturbing it. A read-operation request carries an operation word that names a way, a set and, for instruction data, a word within the line. The engine reads the chosen entry from a behavioural tag RAM or instruction data RAM. It formats the result and latches it into one of two debug result registers: the data-side register or the instruction-side register. A later result read returns the latched value. A load port writes entries into the three RAMs. It uses the same operation-word layout, so the bench can place known entries where the engine will look for them.

For tag reads, the engine rebuilds a full line address. It joins the stored tag bits to the low set-index bits that sit above bit 9. The split between stored and rebuilt bits depends on the way size, which is the number of sets times 32-byte lines. The returned layout is therefore the same for every cache size. Associativity, number of sets and RAM read latency are parameters. The number of sets must be a power of two and at least 32.

Both the request side and the result side use valid/ready. A request is taken on a cycle where `op_valid` and `op_ready` are both high. `op_ready` is low from the cycle after a read is started until its result is captured. A result read completes on a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` falls during the same busy window, so a read issued mid-operation stalls and then returns the new value. `rd_data` is valid in the handshake cycle. The requester must hold `rd_valid` and `rd_sel` steady until `rd_ready` is high.

Top module: `dbg_cache_peek`

## Requirements
- R1: After reset both debug result registers read 0, `busy` is 0, and `op_ready` and `rd_ready` are 1.
- R2: `op_sel`=0 (data tag read) captures into the data-side register. The captured word holds: the stored tag in the top bits, the rebuilt index bits, the stored dirty pair in [2:1], the stored valid bit in [0], and zeros in [9:3].
- R3: `op_sel`=1 (instruction tag read) captures into the instruction-side register with the same layout, except that bits [2:1] are always 0.
- R4: `op_sel`=2 (instruction data read) captures the addressed 32-bit word unchanged into the instruction-side register.
- R5: Operation-word layout. The way is in the top ceil(log2(WAYS)) bits. The set is in bits [S+4:5], where S=log2(SETS). The word is in bits [4:2].
- R6: Tag address rebuild by way size W=SETS*32 bytes. For W>=4KB, the tag supplies [31:12] and set bits supply [11:10]. For 2KB, the tag supplies [31:11] and the set supplies [10]. For 1KB, the tag supplies [31:10]. Set bit j always lands on address bit j+5.
- R7: After an accepted read, `busy` stays high for exactly LAT cycles, and `op_ready` is low during that time.
- R8: A result read issued while busy sees `rd_ready` low. It completes after the capture and returns the new value.
- R9: A read targeting one result register leaves the other unchanged.
- R10: `op_sel`=3 is accepted and discarded. `busy` stays low and both result registers are unchanged.
- R11: The load port writes the RAM chosen by `ld_sel` (0, 1 or 2, as for `op_sel`) at the location that `ld_word` decodes to, using the R5 layout. A tag load stores `ld_data` tag bits in their address positions plus `ld_data`[2:0]. A later read returns the newest load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Read-operation request valid |
| op_ready | output | 1 | Engine can take a request |
| op_sel | input | 2 | 0 data tag, 1 instruction tag, 2 instruction data, 3 discarded |
| op_word | input | 32 | Way/set/word operation word |
| ld_valid | input | 1 | RAM load strobe |
| ld_sel | input | 2 | RAM to load, coded as op_sel |
| ld_word | input | 32 | Load location, same layout as op_word |
| ld_data | input | 32 | Load value |
| rd_valid | input | 1 | Result read request |
| rd_ready | output | 1 | Result read can complete |
| rd_sel | input | 1 | 0 data-side register, 1 instruction-side register |
| rd_data | output | 32 | Selected result register |
| busy | output | 1 | A RAM read is in flight |

## Verification
Three instances with 2KB, 4KB and 1KB ways receive the same operation words. A design that took index bits from the wrong set bits, or let the stored tag override them, would return a different value in at least one of them. The bench counts busy cycles and issues a result read in the middle of an operation. An engine that releases early would hand back the previous value, and one that captured late would hold `busy` too long. Dirty bits loaded as ones into the instruction tag RAM expose a missing clear. A mixed sequence of data-side and instruction-side reads, followed by a discarded code-3 request, exposes a capture into the wrong register or a spurious start.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    OP_DTAG  = 2'd0,
    OP_ITAG  = 2'd1,
    OP_IDATA = 2'd2,
    OP_NONE  = 2'd3
  } op_kind_e;

  localparam int LINE_LOG   = 5;   // 32-byte lines
  localparam int WORD_BITS  = 3;   // eight 32-bit words per line
  localparam int FIXED_TOP  = 10;  // lowest address bit carried in a tag word
  localparam int MAX_IDX    = 2;   // index bits above bit 9 at most

  function automatic int idx_bits(input int set_log);
    int wlog;
    wlog = set_log + LINE_LOG;
    if (wlog >= 12) return MAX_IDX;
    return wlog - FIXED_TOP;
  endfunction

endpackage

// File: rtl/dcp_fields.sv
module dcp_fields #(
  parameter int A = 2,
  parameter int S = 6
) (
  input  logic [31:0]  word_i,
  output logic [A-1:0] way_o,
  output logic [S-1:0] set_o,
  output logic [2:0]   wsel_o
);
  assign way_o  = word_i[31 -: A];
  assign set_o  = word_i[S+4:5];
  assign wsel_o = word_i[4:2];

  logic unused_lsb;
  assign unused_lsb = ^word_i[1:0];

  generate
    if (31 - A >= S + 5) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^word_i[31-A:S+5];
    end
  endgenerate
endmodule

// File: rtl/dcp_ram.sv
module dcp_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LAT   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvld
);
  logic [DW-1:0]  mem [DEPTH];
  logic [DW-1:0]  pd  [LAT];
  logic [LAT-1:0] pv;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    pd[0] <= mem[raddr];
    for (int i = 1; i < LAT; i++) pd[i] <= pd[i-1];
  end

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv <= '0;
        else        pv <= re;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv <= '0;
        else        pv <= {pv[LAT-2:0], re};
      end
    end
  endgenerate

  assign rdata = pd[LAT-1];
  assign rvld  = pv[LAT-1];

  // R7: never more than one read travels through the pipe
  p_single_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pv));
endmodule

// File: rtl/dcp_fmt.sv
module dcp_fmt #(
  parameter int S    = 6,
  parameter int IDXB = 1,
  parameter int TAGW = 21
) (
  input  logic [TAGW+2:0] entry_i,
  input  logic [S-1:0]    set_i,
  input  logic            clean_i,
  output logic [31:0]     word_o
);
  logic [1:0] dirty;
  assign dirty = clean_i ? 2'b00 : entry_i[2:1];

  logic unused_set;
  assign unused_set = ^set_i;

  generate
    if (IDXB > 0) begin : g_idx
      assign word_o = {entry_i[TAGW+2:3], set_i[5 +: IDXB], 7'd0, dirty, entry_i[0]};
    end else begin : g_noidx
      assign word_o = {entry_i[TAGW+2:3], 7'd0, dirty, entry_i[0]};
    end
  endgenerate
endmodule

// File: rtl/dbg_cache_peek.sv
module dbg_cache_peek #(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  parameter int LAT  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [1:0]  op_sel,
  input  logic [31:0] op_word,
  input  logic        ld_valid,
  input  logic [1:0]  ld_sel,
  input  logic [31:0] ld_word,
  input  logic [31:0] ld_data,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        busy
);
  import dcp_pkg::*;

  localparam int A    = $clog2(WAYS);
  localparam int S    = $clog2(SETS);
  localparam int IDXB = idx_bits(S);
  localparam int TAGW = 22 - IDXB;
  localparam int TE   = TAGW + 3;
  localparam int TAW  = A + S;
  localparam int DAW  = A + S + WORD_BITS;
  localparam int TDEP = (1 << A) * SETS;
  localparam int DDEP = TDEP * 8;
  localparam int CW   = $clog2(LAT + 2) + 1;

  // field decode of request and load words
  logic [A-1:0] op_way, ld_way;
  logic [S-1:0] op_set, ld_set;
  logic [2:0]   op_wd,  ld_wd;

  dcp_fields #(.A(A), .S(S)) u_opf (
    .word_i(op_word), .way_o(op_way), .set_o(op_set), .wsel_o(op_wd));
  dcp_fields #(.A(A), .S(S)) u_ldf (
    .word_i(ld_word), .way_o(ld_way), .set_o(ld_set), .wsel_o(ld_wd));

  // control
  logic     busy_q;
  op_kind_e kind_q;
  logic [S-1:0] set_q;
  logic     accept, start;
  op_kind_e req_kind, ld_kind;

  assign req_kind = op_kind_e'(op_sel);
  assign ld_kind  = op_kind_e'(ld_sel);
  assign accept   = op_valid && !busy_q;
  assign start    = accept && (req_kind != OP_NONE);
  assign op_ready = !busy_q;
  assign rd_ready = !busy_q;
  assign busy     = busy_q;

  // RAMs
  logic [TE-1:0] dt_q, it_q;
  logic [31:0]   id_q;
  logic          dt_v, it_v, id_v;
  logic [TE-1:0] tag_wdata;
  logic [TAW-1:0] op_taddr, ld_taddr;
  logic [DAW-1:0] op_daddr, ld_daddr;

  assign tag_wdata = {ld_data[31 -: TAGW], ld_data[2:0]};
  assign op_taddr  = {op_way, op_set};
  assign ld_taddr  = {ld_way, ld_set};
  assign op_daddr  = {op_way, op_set, op_wd};
  assign ld_daddr  = {ld_way, ld_set, ld_wd};

  dcp_ram #(.DEPTH(TDEP), .AW(TAW), .DW(TE), .LAT(LAT)) u_dtag (
    .clk(clk), .rst_n(rst_n),
    .we(ld_valid && ld_kind == OP_DTAG), .waddr(ld_taddr), .wdata(tag_wdata),
    .re(start && req_kind == OP_DTAG), .raddr(op_taddr),
    .rdata(dt_q), .rvld(dt_v));

  dcp_ram #(.DEPTH(TDEP), .AW(TAW), .DW(TE), .LAT(LAT)) u_itag (
    .clk(clk), .rst_n(rst_n),
    .we(ld_valid && ld_kind == OP_ITAG), .waddr(ld_taddr), .wdata(tag_wdata),
    .re(start && req_kind == OP_ITAG), .raddr(op_taddr),
    .rdata(it_q), .rvld(it_v));

  dcp_ram #(.DEPTH(DDEP), .AW(DAW), .DW(32), .LAT(LAT)) u_idat (
    .clk(clk), .rst_n(rst_n),
    .we(ld_valid && ld_kind == OP_IDATA), .waddr(ld_daddr), .wdata(ld_data),
    .re(start && req_kind == OP_IDATA), .raddr(op_daddr),
    .rdata(id_q), .rvld(id_v));

  // formatting
  logic [31:0] dt_word, it_word;
  dcp_fmt #(.S(S), .IDXB(IDXB), .TAGW(TAGW)) u_dfmt (
    .entry_i(dt_q), .set_i(set_q), .clean_i(1'b0), .word_o(dt_word));
  dcp_fmt #(.S(S), .IDXB(IDXB), .TAGW(TAGW)) u_ifmt (
    .entry_i(it_q), .set_i(set_q), .clean_i(1'b1), .word_o(it_word));

  // result registers and sequencing
  logic [31:0] ddbg_q, idbg_q;
  logic        done;
  assign done = dt_v || it_v || id_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= OP_NONE;
      set_q  <= '0;
      ddbg_q <= '0;
      idbg_q <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        kind_q <= req_kind;
        set_q  <= op_set;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (dt_v)      ddbg_q <= dt_word;
      if (it_v)      idbg_q <= it_word;
      else if (id_v) idbg_q <= id_q;
    end
  end

  assign rd_data = rd_sel ? idbg_q : ddbg_q;

  logic unused_rd;
  assign unused_rd = rd_valid;

  // checker state: length of the current busy run
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R7: busy never outlasts the RAM latency
  p_bounded_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (run_q < CW'(LAT)));

  // R7: every real request raises busy
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R10: code 3 neither starts a read nor touches results
  p_rsv_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == OP_NONE) |=> (!busy_q && $stable(ddbg_q) && $stable(idbg_q)));

  // R3: instruction tag capture carries clean dirty bits and a zero gap
  p_itag_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind_q == OP_ITAG && done) |=> (idbg_q[9:1] == 9'd0));

  // R2: data tag capture keeps the gap bits zero
  p_dtag_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind_q == OP_DTAG && done) |=> (ddbg_q[9:3] == 7'd0));

  // R9: instruction-side work leaves the data-side register alone
  p_ddbg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind_q != OP_DTAG) |=> $stable(ddbg_q));
endmodule

// File: tb/dbg_cache_peek_test.sv
module dbg_cache_peek_test;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        op_valid = 0, ld_valid = 0, rd_valid = 0, rd_sel = 0;
  logic [1:0]  op_sel = 0, ld_sel = 0;
  logic [31:0] op_word = 0, ld_word = 0, ld_data = 0;

  logic        opr_m, opr_b, opr_s, rdr_m, rdr_b, rdr_s, busy_m, busy_b, busy_s;
  logic [31:0] rdd_m, rdd_b, rdd_s;

  // 2KB way (S=6), 4KB way (S=7), 1KB way (S=5)
  dbg_cache_peek #(.WAYS(4), .SETS(64), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(opr_m), .op_sel(op_sel),
    .op_word(op_word), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_word(ld_word),
    .ld_data(ld_data), .rd_valid(rd_valid), .rd_ready(rdr_m), .rd_sel(rd_sel),
    .rd_data(rdd_m), .busy(busy_m));
  dbg_cache_peek #(.WAYS(2), .SETS(128), .LAT(LAT)) uut_big (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(opr_b), .op_sel(op_sel),
    .op_word(op_word), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_word(ld_word),
    .ld_data(ld_data), .rd_valid(rd_valid), .rd_ready(rdr_b), .rd_sel(rd_sel),
    .rd_data(rdd_b), .busy(busy_b));
  dbg_cache_peek #(.WAYS(4), .SETS(32), .LAT(LAT)) uut_small (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(opr_s), .op_sel(op_sel),
    .op_word(op_word), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_word(ld_word),
    .ld_data(ld_data), .rd_valid(rd_valid), .rd_ready(rdr_s), .rd_sel(rd_sel),
    .rd_data(rdd_s), .busy(busy_s));

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] E1 = 32'h8000_0CA0, E2 = 32'h4000_0420;
  localparam logic [31:0] W1 = 32'hC000_0354, W2 = 32'hC000_0344;
  localparam logic [31:0] D1 = 32'hFEDC_BA97, D2 = 32'h1357_9BDF, D3 = 32'hA5A5_5A5F;
  localparam logic [31:0] D4 = 32'h0F0F_F0F7, D5 = 32'h7654_3211;
  localparam logic [31:0] DD1 = 32'hDEAD_BEEF, DD2 = 32'h0BAD_F00D;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_tag(input int s, input logic [31:0] w,
                                          input logic [31:0] d, input bit inst);
    int ib, tw;
    logic [31:0] tm, im;
    ib = (s + 5 >= 12) ? 2 : (s + 5 - 10);
    tw = 22 - ib;
    tm = 32'hFFFF_FFFF << (32 - tw);
    im = ((32'd1 << ib) - 32'd1) << 10;
    return (d & tm) | (w & im) | (inst ? 32'h0 : (d & 32'h6)) | (d & 32'h1);
  endfunction

  task automatic load(input logic [1:0] sel, input logic [31:0] w, input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1; ld_sel = sel; ld_word = w; ld_data = d;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic issue(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk);
    op_valid = 1; op_sel = sel; op_word = w;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy_m) @(negedge clk);
  endtask

  task automatic rd_all(input logic sel, output logic [31:0] m, output logic [31:0] b,
                        output logic [31:0] s);
    @(negedge clk);
    rd_valid = 1; rd_sel = sel;
    #1;
    m = rdd_m; b = rdd_b; s = rdd_s;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] m, b, s;
    chk("R1 busy", {31'd0, busy_m | busy_b | busy_s}, 32'd0);
    chk("R1 op_ready", {31'd0, opr_m & opr_b & opr_s & rdr_m}, 32'd1);
    rd_all(0, m, b, s); chk("R1 data reg", m | b | s, 32'd0);
    rd_all(1, m, b, s); chk("R1 instr reg", m | b | s, 32'd0);
  endtask

  task automatic t_dtag(); // R2 R5 R6
    logic [31:0] m, b, s;
    issue(0, E1); wait_idle();
    rd_all(0, m, b, s);
    chk("R2 R6 dtag 2KB", m, exp_tag(6, E1, D1, 0));
    chk("R6 dtag 4KB", b, exp_tag(7, E1, D1, 0));
    chk("R6 dtag 1KB", s, exp_tag(5, E1, D1, 0));
    issue(0, E2); wait_idle();
    rd_all(0, m, b, s);
    chk("R5 dtag way/set 2KB", m, exp_tag(6, E2, D2, 0));
    chk("R5 dtag 4KB", b, exp_tag(7, E2, D2, 0));
    chk("R5 dtag 1KB", s, exp_tag(5, E2, D2, 0));
  endtask

  task automatic t_itag(); // R3
    logic [31:0] m, b, s;
    issue(1, E1); wait_idle();
    rd_all(1, m, b, s);
    chk("R3 itag 2KB", m, exp_tag(6, E1, D3, 1));
    chk("R3 itag 4KB", b, exp_tag(7, E1, D3, 1));
    chk("R3 itag 1KB", s, exp_tag(5, E1, D3, 1));
  endtask

  task automatic t_idata(); // R4 R5
    logic [31:0] m, b, s;
    issue(2, W1); wait_idle();
    rd_all(1, m, b, s);
    chk("R4 idata W1", m, DD1); chk("R4 idata W1 4KB", b, DD1); chk("R4 idata W1 1KB", s, DD1);
    issue(2, W2); wait_idle();
    rd_all(1, m, b, s);
    chk("R5 word field W2", m, DD2); chk("R5 word W2 1KB", s, DD2);
  endtask

  task automatic t_busy(); // R7
    int n;
    issue(2, W1);
    n = 0;
    while (busy_m) begin
      if (opr_m) chk("R7 op_ready low while busy", {31'd0, opr_m}, 32'd0);
      n++;
      @(negedge clk);
    end
    chk("R7 busy length", n, LAT);
  endtask

  task automatic t_stall(); // R8
    int n;
    issue(1, E2);
    rd_valid = 1; rd_sel = 1;
    #1;
    chk("R8 rd_ready low while busy", {31'd0, rdr_m}, 32'd0);
    n = 0;
    while (!rdr_m && n < 20) begin @(negedge clk); #1; n++; end
    chk("R8 stalled read value", rdd_m, exp_tag(6, E2, D4, 1));
    chk("R8 stalled read 4KB", rdd_b, exp_tag(7, E2, D4, 1));
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic t_indep(); // R9
    logic [31:0] m, b, s;
    issue(0, E1); wait_idle();
    issue(2, W2); wait_idle();
    rd_all(0, m, b, s);
    chk("R9 data reg kept", m, exp_tag(6, E1, D1, 0));
    rd_all(1, m, b, s);
    chk("R9 instr reg updated", m, DD2);
    issue(1, E1); wait_idle();
    rd_all(0, m, b, s);
    chk("R9 data reg kept after itag", m, exp_tag(6, E1, D1, 0));
  endtask

  task automatic t_rsv(); // R10
    logic [31:0] m, b, s;
    issue(3, E2);
    chk("R10 no busy", {31'd0, busy_m | busy_b | busy_s}, 32'd0);
    repeat (LAT + 1) @(negedge clk);
    rd_all(0, m, b, s); chk("R10 data reg unchanged", m, exp_tag(6, E1, D1, 0));
    rd_all(1, m, b, s); chk("R10 instr reg unchanged", m, exp_tag(6, E1, D3, 1));
  endtask

  task automatic t_reload(); // R11
    logic [31:0] m, b, s;
    load(0, E1, D5);
    issue(0, E1); wait_idle();
    rd_all(0, m, b, s);
    chk("R11 reload 2KB", m, exp_tag(6, E1, D5, 0));
    chk("R11 reload 4KB", b, exp_tag(7, E1, D5, 0));
    chk("R11 reload 1KB", s, exp_tag(5, E1, D5, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    load(0, E1, D1); load(0, E2, D2);
    load(1, E1, D3); load(1, E2, D4);
    load(2, W1, DD1); load(2, W2, DD2);
    t_dtag();
    t_itag();
    t_idata();
    t_busy();
    t_stall();
    t_indep();
    t_rsv();
    t_reload();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule